// File: doc/BRIEF.md
# Aliased Partial-Width Register File

This block holds four 32-bit general-purpose registers. Software running on the surrounding core can see each register in four overlapping ways: as the full 32-bit double-word, as its low 16-bit word, or as either byte of that word. All four views share the same storage. A write through a narrow view merges its bits into the register and leaves every other bit as it was.

There is one write port and two read ports. Each port carries a register index and a 2-bit size code. Reads are combinational and return the selected field shifted down to bit 0, with zeros above it. A read of the register that is being written in the same cycle sees the merged result of that write. The bypass works bit by bit, so bits outside the written field come from the stored contents. Reset is synchronous and active high.

Top module: `aprf_regfile`

## Requirements
- R1: A synchronous active-high reset sets all four registers to zero. Reset takes priority over a write in the same cycle.
- R2: The size code is 00 = low byte (bits 7:0), 01 = high byte (bits 15:8), 10 = word (bits 15:0), 11 = double-word (bits 31:0). A double-word write replaces all 32 bits with wr_data.
- R3: A low-byte write stores wr_data[7:0] into bits 7:0. Bits 31:8 keep their values.
- R4: A high-byte write stores wr_data[7:0] into bits 15:8. Bits 31:16 and 7:0 keep their values.
- R5: A word write stores wr_data[15:0] into bits 15:0. Bits 31:16 keep their values.
- R6: Byte and word reads return the field right-aligned on rd_*_data and zero-extended to 32 bits. A high-byte read puts bits 15:8 on output bits 7:0.
- R7: The two read ports work independently. Each can select any register and any size in the same cycle, including the same register at different sizes.
- R8: When a read port selects the register being written, it returns the merged value of that write in the same cycle. Bits outside the written field show the old contents.
- R9: While wr_en is low, no register changes, whatever the write index, size and data are.
- R10: Registers 0 to 3 are separate storage. A write to one register does not alter any other register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 2 | Register written |
| wr_sz | input | 2 | Size code of the write |
| wr_data | input | 32 | Write data; narrow writes take its low bits |
| rd_a_idx | input | 2 | Register read by port A |
| rd_a_sz | input | 2 | Size code of port A |
| rd_a_data | output | 32 | Port A result, zero-extended |
| rd_b_idx | input | 2 | Register read by port B |
| rd_b_sz | input | 2 | Size code of port B |
| rd_b_data | output | 32 | Port B result, zero-extended |

## Verification
The properties assume that the index and size inputs are always known values. The hold and commit checks also assume that the read selection on port A can stay the same from one cycle to the next. The bypass checks take for granted that the default write-first variant is selected. The stimulus drives every index and size input with a defined value on every cycle, away from the clock edge. It repeats the read selection across steps so that these conditional properties actually fire. It never leaves a port undriven after reset.

// File: rtl/aprf_pkg.sv
package aprf_pkg;

   // Access size codes shared by all ports
   typedef enum logic [1:0] {
      ACC_LO8 = 2'b00,
      ACC_HI8 = 2'b01,
      ACC_W16 = 2'b10,
      ACC_D32 = 2'b11
   } acc_sz_e;

endpackage

// File: rtl/aprf_field_map.sv
// Turns a size code into the bit mask and right-shift of the field it selects.
module aprf_field_map #(
   parameter int DATA_W = 32,
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic [1:0]        sz,
   output logic [DATA_W-1:0] mask,
   output logic [SH_W-1:0]   shift
);
   import aprf_pkg::*;

   localparam logic [DATA_W-1:0] LO_MASK =
      {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
   localparam logic [DATA_W-1:0] WORD_MASK =
      {{(DATA_W-WORD_W){1'b0}}, {WORD_W{1'b1}}};
   localparam logic [DATA_W-1:0] HI_MASK = LO_MASK << BYTE_W;

   always_comb begin
      mask  = '1;
      shift = '0;
      case (acc_sz_e'(sz))
         ACC_LO8: begin
            mask  = LO_MASK;
            shift = '0;
         end
         ACC_HI8: begin
            mask  = HI_MASK;
            shift = SH_W'(BYTE_W);
         end
         ACC_W16: begin
            mask  = WORD_MASK;
            shift = '0;
         end
         default: begin
            mask  = '1;
            shift = '0;
         end
      endcase
   end

endmodule

// File: rtl/aprf_write_merge.sv
// Places narrow write data into its field and merges it with the old value.
module aprf_write_merge #(
   parameter int DATA_W = 32,
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] old_val,
   input  logic [DATA_W-1:0] wdata,
   input  logic [1:0]        sz,
   output logic [DATA_W-1:0] merged
);
   localparam int SH_W = $clog2(DATA_W);

   logic [DATA_W-1:0] fld_mask;
   logic [SH_W-1:0]   fld_shift;
   logic [DATA_W-1:0] placed;

   aprf_field_map #(
      .DATA_W(DATA_W),
      .WORD_W(WORD_W),
      .BYTE_W(BYTE_W)
   ) i_map (
      .sz   (sz),
      .mask (fld_mask),
      .shift(fld_shift)
   );

   always_comb begin
      placed = (wdata << fld_shift) & fld_mask;
      merged = (old_val & ~fld_mask) | placed;
   end

endmodule

// File: rtl/aprf_read_extract.sv
// Selects a field from a register value, right-aligned and zero-extended.
module aprf_read_extract #(
   parameter int DATA_W = 32,
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8
) (
   input  logic [DATA_W-1:0] value,
   input  logic [1:0]        sz,
   output logic [DATA_W-1:0] rdata
);
   localparam int SH_W = $clog2(DATA_W);

   logic [DATA_W-1:0] fld_mask;
   logic [SH_W-1:0]   fld_shift;

   aprf_field_map #(
      .DATA_W(DATA_W),
      .WORD_W(WORD_W),
      .BYTE_W(BYTE_W)
   ) i_map (
      .sz   (sz),
      .mask (fld_mask),
      .shift(fld_shift)
   );

   always_comb rdata = (value & fld_mask) >> fld_shift;

endmodule

// File: rtl/aprf_regfile.sv
// Register file with aliased byte / word / double-word views.
module aprf_regfile #(
   parameter int DATA_W   = 32,
   parameter int WORD_W   = 16,
   parameter int BYTE_W   = 8,
   parameter int NUM_REGS = 4,
   parameter bit BYPASS   = 1'b1,
   localparam int IDX_W   = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [1:0]        wr_sz,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_a_idx,
   input  logic [1:0]        rd_a_sz,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [IDX_W-1:0]  rd_b_idx,
   input  logic [1:0]        rd_b_sz,
   output logic [DATA_W-1:0] rd_b_data
);
   localparam int NUM_RD = 2;

   // Elaboration-time parameter checks
   if (WORD_W != 2 * BYTE_W) begin : g_bad_word
      $error("aprf_regfile: WORD_W must be twice BYTE_W");
   end
   if (DATA_W <= WORD_W) begin : g_bad_data
      $error("aprf_regfile: DATA_W must exceed WORD_W");
   end
   if (NUM_REGS != (1 << IDX_W)) begin : g_bad_regs
      $error("aprf_regfile: NUM_REGS must be a power of two");
   end

   logic [DATA_W-1:0] regs [NUM_REGS];
   logic [DATA_W-1:0] wr_merged;

   aprf_write_merge #(
      .DATA_W(DATA_W),
      .WORD_W(WORD_W),
      .BYTE_W(BYTE_W)
   ) i_merge (
      .old_val(regs[wr_idx]),
      .wdata  (wr_data),
      .sz     (wr_sz),
      .merged (wr_merged)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      end else if (wr_en) begin
         regs[wr_idx] <= wr_merged;
      end
   end

   // Read ports
   logic [IDX_W-1:0]  rp_idx  [NUM_RD];
   logic [1:0]        rp_sz   [NUM_RD];
   logic [DATA_W-1:0] rp_data [NUM_RD];

   assign rp_idx[0]  = rd_a_idx;
   assign rp_idx[1]  = rd_b_idx;
   assign rp_sz[0]   = rd_a_sz;
   assign rp_sz[1]   = rd_b_sz;
   assign rd_a_data  = rp_data[0];
   assign rd_b_data  = rp_data[1];

   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      logic [DATA_W-1:0] src;

      if (BYPASS) begin : g_wfirst
         // merged value already keeps the untouched bits of the old contents
         always_comb src = (wr_en && (wr_idx == rp_idx[p])) ? wr_merged
                                                            : regs[rp_idx[p]];
      end else begin : g_rfirst
         always_comb src = regs[rp_idx[p]];
      end

      aprf_read_extract #(
         .DATA_W(DATA_W),
         .WORD_W(WORD_W),
         .BYTE_W(BYTE_W)
      ) i_ext (
         .value(src),
         .sz   (rp_sz[p]),
         .rdata(rp_data[p])
      );
   end

endmodule

// File: rtl/aprf_checker.sv
module aprf_checker #(
   parameter int DATA_W = 32,
   parameter int WORD_W = 16,
   parameter int BYTE_W = 8,
   parameter int IDX_W  = 2,
   parameter bit BYPASS = 1'b1
) (
   input logic              clk,
   input logic              rst,
   input logic              wr_en,
   input logic [IDX_W-1:0]  wr_idx,
   input logic [1:0]        wr_sz,
   input logic [DATA_W-1:0] wr_data,
   input logic [IDX_W-1:0]  rd_a_idx,
   input logic [1:0]        rd_a_sz,
   input logic [DATA_W-1:0] rd_a_data,
   input logic [IDX_W-1:0]  rd_b_idx,
   input logic [1:0]        rd_b_sz,
   input logic [DATA_W-1:0] rd_b_data
);
   import aprf_pkg::*;

   logic a_hit;
   assign a_hit = wr_en && (wr_idx == rd_a_idx);

   AST_RST_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) && !wr_en |-> rd_a_data == '0 && rd_b_data == '0); // R1

   AST_BYTE_ZEXT_A: assert property (@(posedge clk) disable iff (rst)
      (rd_a_sz == ACC_LO8 || rd_a_sz == ACC_HI8) |->
         rd_a_data[DATA_W-1:BYTE_W] == '0); // R6

   AST_BYTE_ZEXT_B: assert property (@(posedge clk) disable iff (rst)
      (rd_b_sz == ACC_LO8 || rd_b_sz == ACC_HI8) |->
         rd_b_data[DATA_W-1:BYTE_W] == '0); // R6

   AST_WORD_ZEXT: assert property (@(posedge clk) disable iff (rst)
      rd_a_sz == ACC_W16 |-> rd_a_data[DATA_W-1:WORD_W] == '0); // R6

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      !$past(wr_en) && !$past(rst) && rd_a_idx == $past(rd_a_idx) &&
      rd_a_sz == $past(rd_a_sz) && !a_hit |-> $stable(rd_a_data)); // R9

   if (BYPASS) begin : g_bypass_chk
      AST_BYPASS_LO: assert property (@(posedge clk) disable iff (rst)
         a_hit && wr_sz == ACC_LO8 && rd_a_sz == ACC_D32 |->
            rd_a_data[BYTE_W-1:0] == wr_data[BYTE_W-1:0]); // R8

      AST_BYPASS_WORD: assert property (@(posedge clk) disable iff (rst)
         a_hit && wr_sz == ACC_W16 && rd_a_sz == ACC_D32 |->
            rd_a_data[WORD_W-1:0] == wr_data[WORD_W-1:0]); // R5

      AST_COMMIT_MATCH: assert property (@(posedge clk) disable iff (rst)
         $past(a_hit) && !$past(rst) && rd_a_idx == $past(rd_a_idx) &&
         rd_a_sz == $past(rd_a_sz) && !a_hit |->
            rd_a_data == $past(rd_a_data)); // R8
   end

endmodule

bind aprf_regfile aprf_checker #(
   .DATA_W(DATA_W),
   .WORD_W(WORD_W),
   .BYTE_W(BYTE_W),
   .IDX_W (IDX_W),
   .BYPASS(BYPASS)
) i_aprf_checker (
   .clk      (clk),
   .rst      (rst),
   .wr_en    (wr_en),
   .wr_idx   (wr_idx),
   .wr_sz    (wr_sz),
   .wr_data  (wr_data),
   .rd_a_idx (rd_a_idx),
   .rd_a_sz  (rd_a_sz),
   .rd_a_data(rd_a_data),
   .rd_b_idx (rd_b_idx),
   .rd_b_sz  (rd_b_sz),
   .rd_b_data(rd_b_data)
);

// File: tb/test_aprf_regfile.sv
module test_aprf_regfile;

   logic        clk = 1'b0;
   logic        rst;
   logic        wr_en;
   logic [1:0]  wr_idx, wr_sz;
   logic [31:0] wr_data;
   logic [1:0]  rd_a_idx, rd_a_sz, rd_b_idx, rd_b_sz;
   logic [31:0] rd_a_data, rd_b_data;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk; // 250 MHz

   aprf_regfile i_aprf_regfile (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_sz    (wr_sz),
      .wr_data  (wr_data),
      .rd_a_idx (rd_a_idx),
      .rd_a_sz  (rd_a_sz),
      .rd_a_data(rd_a_data),
      .rd_b_idx (rd_b_idx),
      .rd_b_sz  (rd_b_sz),
      .rd_b_data(rd_b_data)
   );

   // size codes: 00 low byte, 01 high byte, 10 word, 11 double-word
   typedef struct packed {
      logic        we;
      logic [1:0]  wi;
      logic [1:0]  ws;
      logic [31:0] wd;
      logic [1:0]  ai;
      logic [1:0]  asz;
      logic [31:0] ea;
      logic [1:0]  bi;
      logic [1:0]  bsz;
      logic [31:0] eb;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      // R2 full write, bypass on A, untouched r1 on B
      '{1'b1, 2'd0, 2'b11, 32'h11223344, 2'd0, 2'b11, 32'h11223344, 2'd1, 2'b11, 32'h0, 4'd2},
      // R6 byte views of r0
      '{1'b0, 2'd0, 2'b00, 32'h0, 2'd0, 2'b00, 32'h44, 2'd0, 2'b01, 32'h33, 4'd6},
      // R7 same register, two sizes
      '{1'b0, 2'd0, 2'b00, 32'h0, 2'd0, 2'b10, 32'h3344, 2'd0, 2'b11, 32'h11223344, 4'd7},
      // R3 low byte merge, R8 bypass
      '{1'b1, 2'd0, 2'b00, 32'hFFFFFFAA, 2'd0, 2'b11, 32'h112233AA, 2'd0, 2'b01, 32'h33, 4'd3},
      // R4 high byte merge
      '{1'b1, 2'd0, 2'b01, 32'h000000BB, 2'd0, 2'b11, 32'h1122BBAA, 2'd0, 2'b00, 32'hAA, 4'd4},
      // R10 write r1, r0 intact
      '{1'b1, 2'd1, 2'b11, 32'hDEADBEEF, 2'd0, 2'b11, 32'h1122BBAA, 2'd1, 2'b10, 32'hBEEF, 4'd10},
      // R5 word merge
      '{1'b1, 2'd1, 2'b10, 32'h12345678, 2'd1, 2'b11, 32'hDEAD5678, 2'd1, 2'b01, 32'h56, 4'd5},
      // R9 disabled write has no effect
      '{1'b0, 2'd1, 2'b11, 32'h0, 2'd1, 2'b11, 32'hDEAD5678, 2'd1, 2'b00, 32'h78, 4'd9},
      // R4 high byte into zero register
      '{1'b1, 2'd2, 2'b01, 32'h0000007E, 2'd2, 2'b11, 32'h00007E00, 2'd3, 2'b11, 32'h0, 4'd4},
      // R8 bypass on narrow read
      '{1'b1, 2'd3, 2'b00, 32'h00000081, 2'd3, 2'b00, 32'h81, 2'd2, 2'b01, 32'h7E, 4'd8},
      // R10 four registers distinct
      '{1'b0, 2'd0, 2'b00, 32'h0, 2'd3, 2'b11, 32'h81, 2'd0, 2'b10, 32'hBBAA, 4'd10},
      // R6 all-ones zero-extension
      '{1'b1, 2'd3, 2'b11, 32'hFFFFFFFF, 2'd3, 2'b10, 32'hFFFF, 2'd3, 2'b01, 32'hFF, 4'd6},
      // R5 word clear keeps upper half
      '{1'b1, 2'd3, 2'b10, 32'h0, 2'd3, 2'b11, 32'hFFFF0000, 2'd2, 2'b11, 32'h00007E00, 4'd5},
      // R10 committed state
      '{1'b0, 2'd0, 2'b00, 32'h0, 2'd1, 2'b11, 32'hDEAD5678, 2'd3, 2'b11, 32'hFFFF0000, 4'd10}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic idle();
      wr_en = 1'b0; wr_idx = '0; wr_sz = '0; wr_data = '0;
      rd_a_idx = '0; rd_a_sz = 2'b11; rd_b_idx = '0; rd_b_sz = 2'b11;
   endtask

   task automatic check_all_zero(input string tag);
      for (int r = 0; r < 4; r += 2) begin
         @(negedge clk);
         rd_a_idx = 2'(r);   rd_a_sz = 2'b11;
         rd_b_idx = 2'(r+1); rd_b_sz = 2'b11;
         #1;
         chk(tag, rd_a_data, 32'h0);
         chk(tag, rd_b_data, 32'h0);
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R1..all actual=timeout expected=finish");
         summary();
         $finish;
      end
   end

   initial begin
      idle();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;

      // R1 reset state
      check_all_zero("R1 reset state");

      // table walk: drive at negedge, sample before the committing edge
      for (int v = 0; v < NV; v++) begin
         @(negedge clk);
         wr_en = VECS[v].we; wr_idx = VECS[v].wi; wr_sz = VECS[v].ws; wr_data = VECS[v].wd;
         rd_a_idx = VECS[v].ai; rd_a_sz = VECS[v].asz;
         rd_b_idx = VECS[v].bi; rd_b_sz = VECS[v].bsz;
         #1;
         chk($sformatf("R%0d vec%0d port A", VECS[v].rq, v), rd_a_data, VECS[v].ea);
         chk($sformatf("R%0d vec%0d port B", VECS[v].rq, v), rd_b_data, VECS[v].eb);
      end
      @(negedge clk);
      idle();

      // R1 reset wins over a simultaneous write
      @(negedge clk);
      rst = 1'b1; wr_en = 1'b1; wr_idx = 2'd2; wr_sz = 2'b11; wr_data = 32'hCAFE0001;
      @(negedge clk);
      rst = 1'b0; idle();
      check_all_zero("R1 reset over write");

      // R9 disabled write with every field set leaves register zero
      @(negedge clk);
      wr_en = 1'b0; wr_idx = 2'd1; wr_sz = 2'b01; wr_data = 32'h5A5A5A5A;
      rd_a_idx = 2'd1; rd_a_sz = 2'b11;
      @(negedge clk);
      idle(); rd_a_idx = 2'd1;
      #1;
      chk("R9 write disabled", rd_a_data, 32'h0);

      // R3 low byte write ignores upper wr_data bits
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 2'd0; wr_sz = 2'b00; wr_data = 32'h123456C3;
      @(negedge clk);
      idle(); rd_a_idx = 2'd0; rd_b_idx = 2'd0; rd_b_sz = 2'b01;
      #1;
      chk("R3 low byte only", rd_a_data, 32'h000000C3);
      chk("R6 high byte zero", rd_b_data, 32'h0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule